// File: doc/BRIEF.md
# Serial Command Slave with Pause and Strap Addressing

This block is the serial front end of a multi-channel register device. A mode 0 master frames each transfer with an active-low select, clocks command, register address and data into the block on a serial input, and receives read data back on a serial output. The block oversamples the serial clock, select, pause and data pins on a system clock at least eight times faster than the serial clock, so all of its logic lives in one clock domain.

A transfer is three bytes, most significant bit first. The first byte carries an operation code and a device field. A command acts only when that field equals the two strap inputs, so four devices can share one bus. An active-low pause input freezes a transfer in the middle of a byte. While paused, the output driver is released and the serial clock and data pins are ignored. After the pause is released, shifting resumes at the bit where it stopped. Completed writes leave the block as a one-cycle valid strobe with register address and data. Reads fetch one byte from the register side through a one-cycle request.

Neither register-side interface accepts back-pressure, and there is no ready input. The serial stream cannot be stalled, so the consumer must take a write in the cycle its valid is high. The register side must present read data in the cycle its request is high.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, and whenever select is high, `so_oe` is low and no write strobe or read request is issued.
- R2: Serial input is captured on rising serial clock edges, and `so` changes only after falling edges. Both directions are most significant bit first.
- R3: Byte 1 bits [7:4] are the operation code (4'h2 write, 4'h3 read) and bits [3:2] are the device field. Byte 2 bits [3:2] select the channel and bits [1:0] select the register, forming the 4-bit register address {channel, register}. Byte 3 is write data.
- R4: After the last rising edge of byte 3 of a matching write, `wr_valid` is high for exactly one system cycle with `wr_addr` and `wr_data`.
- R5: At the end of byte 2 of a matching read, `rd_req` pulses for one cycle with `rd_addr`, and `rd_data` is captured in that cycle. Its MSB appears on `so` after the next falling edge, with `so_oe` high from then until select rises.
- R6: A command whose device field differs from `dev_id` produces no write strobe and no read request, and leaves `so_oe` low.
- R7: Any operation code other than write or read is ignored in the same way.
- R8: A pause input taken low while the serial clock is high has no effect until the clock is low. Release is also taken only while the clock is low.
- R9: While paused, `so_oe` is low and serial clock and data transitions are ignored. The bit position is kept, so the transfer completes correctly after release.
- R10: Select rising mid-frame discards the partial frame, and the next frame starts from byte 1.
- R11: A frame is accepted only after a high-to-low select transition. Select held low from reset enables nothing.
- R12: If select rises in the same sampled cycle as the final rising edge of a write, the deselect wins and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select framing a transfer |
| sck | input | 1 | Serial clock from the master (mode 0) |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause request |
| dev_id | input | 2 | Strap inputs giving this device's identity |
| so | output | 1 | Serial data out, meaningful only while so_oe is high |
| so_oe | output | 1 | Output enable for the serial data driver |
| wr_valid | output | 1 | One-cycle strobe for a completed write, no back-pressure |
| wr_addr | output | 4 | Register address of the write, {channel, register} |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | One-cycle read request, no back-pressure |
| rd_addr | output | 4 | Register address of the read |
| rd_data | input | 8 | Read data, valid in the cycle rd_req is high |

## Verification
Two pairs of events can land in the same sampled system cycle. The first pair is a deselect and the final rising edge of a write. The bench provokes it by raising select and the serial clock in the same timestep, and it judges the result by the absence of any write strobe. The second pair is a pause entry and a falling serial clock edge. The bench lowers the pause input during the clock's high phase of a read-data bit. It then requires `so_oe` to stay high until the clock falls, drop after that, and the remaining read bits to arrive intact after release.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int BYTE_W  = 8;
  localparam int OPC_W   = 4;
  localparam int DEV_W   = 2;
  localparam int RADDR_W = 4;
  localparam int OPC_LSB = BYTE_W - OPC_W;
  localparam int DEV_LSB = OPC_LSB - DEV_W;
  localparam int CNT_W   = $clog2(BYTE_W);

  localparam logic [OPC_W-1:0] OPC_WR = 4'h2;
  localparam logic [OPC_W-1:0] OPC_RD = 4'h3;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_TAIL} phase_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
          chain[0] <= d;
          for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic hold_lvl,
  input  logic sck_lvl,
  output logic paused
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        paused <= 1'b0;
    else if (!sel)     paused <= 1'b0;
    else if (!sck_lvl) paused <= !hold_lvl;
  end

  // R8
  hold_enter_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sck_lvl));

  // R8
  hold_leave_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> (!$past(sck_lvl) || !$past(sel)));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         so_bit,
  output logic         driving
);
  logic [W-1:0] sr;
  logic         loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; loaded <= 1'b0; so_bit <= 1'b0; driving <= 1'b0;
    end else if (clr) begin
      sr <= '0; loaded <= 1'b0; so_bit <= 1'b0; driving <= 1'b0;
    end else if (load) begin
      sr     <= load_data;
      loaded <= 1'b1;
    end else if (shift && loaded) begin
      so_bit  <= sr[W-1];
      sr      <= {sr[W-2:0], 1'b0};
      driving <= 1'b1;
    end
  end

  // R2
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(driving) |-> $past(shift));

  // R5
  drive_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    driving |-> loaded);
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               si,
  input  logic               hold_n,
  input  logic [DEV_W-1:0]   dev_id,
  output logic               so,
  output logic               so_oe,
  output logic               wr_valid,
  output logic [RADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0]  wr_data,
  output logic               rd_req,
  output logic [RADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0]  rd_data
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pins_s;
  logic cs_hi, sck_s, si_s, hold_s;
  logic sck_d, cs_d, armed, paused;
  logic sck_rise, sck_fall, cs_fall, step, byte_done;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, next_byte;
  logic [OPC_W-1:0]  opc;
  logic              hit;
  logic [RADDR_W-1:0] reg_addr;
  phase_e            phase;
  logic              tx_driving;

  spi_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({hold_n, si, sck, cs_n}), .q(pins_s));

  assign {hold_s, si_s, sck_s, cs_hi} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b0; armed <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_hi;
      if (cs_hi)        armed <= 1'b0;
      else if (cs_fall) armed <= 1'b1;
    end
  end

  assign sck_rise  = sck_s & ~sck_d;
  assign sck_fall  = ~sck_s & sck_d;
  assign cs_fall   = ~cs_hi & cs_d;
  assign step      = armed & ~cs_hi & ~paused & sck_rise;
  assign byte_done = step && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign next_byte = {shreg[BYTE_W-2:0], si_s};

  spi_hold_ctl i_hold (
    .clk(clk), .rst_n(rst_n), .sel(armed & ~cs_hi), .hold_lvl(hold_s),
    .sck_lvl(sck_s), .paused(paused));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; shreg <= '0; phase <= PH_CMD; opc <= '0; hit <= 1'b0;
      reg_addr <= '0; wr_valid <= 1'b0; wr_data <= '0; rd_req <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (cs_hi) begin
        bit_cnt <= '0; shreg <= '0; phase <= PH_CMD; hit <= 1'b0;
      end else if (step) begin
        shreg   <= next_byte;
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_done) begin
          bit_cnt <= '0;
          if (phase != PH_TAIL) phase <= phase_e'(phase + 2'd1);
          case (phase)
            PH_CMD: begin
              opc <= next_byte[BYTE_W-1:OPC_LSB];
              hit <= (next_byte[OPC_LSB-1:DEV_LSB] == dev_id) &&
                     ((next_byte[BYTE_W-1:OPC_LSB] == OPC_WR) ||
                      (next_byte[BYTE_W-1:OPC_LSB] == OPC_RD));
            end
            PH_ADDR: begin
              reg_addr <= next_byte[RADDR_W-1:0];
              rd_req   <= hit && (opc == OPC_RD);
            end
            PH_DATA: begin
              if (hit && (opc == OPC_WR)) begin
                wr_valid <= 1'b1;
                wr_data  <= next_byte;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign wr_addr = reg_addr;
  assign rd_addr = reg_addr;

  spi_tx_shift #(.W(BYTE_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .clr(cs_hi), .load(rd_req), .load_data(rd_data),
    .shift(sck_fall & armed & ~paused), .so_bit(so), .driving(tx_driving));

  assign so_oe = tx_driving & ~paused & ~cs_hi;

  // R4
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R5
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R9
  hold_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(paused) && !$past(cs_hi)) |-> $stable(bit_cnt));

  // R11
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(armed) |-> (!wr_valid && !rd_req));
endmodule

// File: tb/test_spi_hold_slave.sv
module test_spi_hold_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [1:0] dev_id = 2'b10;
  logic so, so_oe, wr_valid, rd_req;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [11:0] exp_wr[$];
  logic [3:0]  exp_rd[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] reg_model(input logic [3:0] a);
    return {a, ~a} ^ 8'h5A;
  endfunction

  assign rd_data = reg_model(rd_addr);

  spi_hold_slave i_spi_hold_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .dev_id(dev_id), .so(so), .so_oe(so_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every-clock comparison of the register-side strobes against the model queues
  initial begin
    forever begin
      @(negedge clk);
      if (wr_valid) begin
        if (exp_wr.size() == 0) check(0, {cur_req, " unexpected write"}, {4'h0, wr_addr, wr_data}, 16'h0);
        else begin
          logic [11:0] e;
          e = exp_wr.pop_front();
          check({wr_addr, wr_data} == e, "R4 write content", {4'h0, wr_addr, wr_data}, {4'h0, e});
        end
      end
      if (rd_req) begin
        if (exp_rd.size() == 0) check(0, {cur_req, " unexpected read"}, {12'h0, rd_addr}, 16'h0);
        else begin
          logic [3:0] e;
          e = exp_rd.pop_front();
          check(rd_addr == e, "R5 read address", {12'h0, rd_addr}, {12'h0, e});
        end
      end
    end
  end

  // hmode: 0 none, 1 pause in low phase, 2 pause requested in high phase
  task automatic xfer(input logic [23:0] bits, input int nbits, input int hmode,
                      input int hbit, input bit is_rd, input bit desel_last);
    logic [7:0] exp_byte;
    exp_byte = reg_model(bits[11:8]);
    @(negedge clk); cs_n = 1'b0;
    wait_n(HALF_SCK);
    for (int k = 0; k < nbits; k++) begin
      si = bits[23-k];
      wait_n(HALF_SCK);
      if (hmode == 1 && k == hbit) begin
        hold_n = 1'b0;
        wait_n(20);
        check(so_oe == 1'b0, "R9 paused oe", {15'h0, so_oe}, 16'h0);
        si = ~si; sck = 1'b1; wait_n(6); sck = 1'b0; si = ~si; wait_n(6);
        si = bits[23-k]; wait_n(2);
        hold_n = 1'b1;
        wait_n(HALF_SCK);
      end
      if (k >= 16) begin
        if (is_rd) begin
          check(so_oe == 1'b1, "R5 read oe", {15'h0, so_oe}, 16'h1);
          check(so == exp_byte[23-k], "R2 read bit", {15'h0, so}, {15'h0, exp_byte[23-k]});
        end else begin
          check(so_oe == 1'b0, {cur_req, " oe idle"}, {15'h0, so_oe}, 16'h0);
        end
      end
      if (desel_last && k == nbits - 1) begin
        sck = 1'b1; cs_n = 1'b1;
        wait_n(2 * HALF_SCK);
        sck = 1'b0;
      end else begin
        sck = 1'b1;
        wait_n(HALF_SCK / 2);
        if (hmode == 2 && k == hbit) begin
          hold_n = 1'b0;
          wait_n(HALF_SCK / 2);
          check(so_oe == (is_rd && k >= 16), "R8 no pause while clock high",
                {15'h0, so_oe}, {15'h0, is_rd && k >= 16});
          sck = 1'b0;
          wait_n(20);
          check(so_oe == 1'b0, "R9 paused oe", {15'h0, so_oe}, 16'h0);
          si = ~si;
          wait_n(4);
          hold_n = 1'b1;
          wait_n(4);
        end else begin
          wait_n(HALF_SCK / 2);
          sck = 1'b0;
        end
      end
    end
    wait_n(HALF_SCK);
    cs_n = 1'b1;
    wait_n(12);
    check(so_oe == 1'b0, "R1 oe off when deselected", {15'h0, so_oe}, 16'h0);
    wait_n(HALF_SCK);
  endtask

  initial begin
    cur_req = "R1";
    wait_n(4);
    check(so_oe == 1'b0, "R1 reset oe", {15'h0, so_oe}, 16'h0);
    check(wr_valid == 1'b0 && rd_req == 1'b0, "R1 reset strobes", {14'h0, wr_valid, rd_req}, 16'h0);
    rst_n = 1'b1;
    wait_n(4);

    // R11: select low since reset, no falling edge seen
    cur_req = "R11";
    xfer({8'h28, 8'h01, 8'h77}, 24, 0, 0, 1'b0, 1'b0);

    // R3 R4: matching writes with two patterns
    cur_req = "R4";
    exp_wr.push_back({4'hB, 8'hA5});
    xfer({8'h28, 8'h0B, 8'hA5}, 24, 0, 0, 1'b0, 1'b0);
    cur_req = "R3";
    exp_wr.push_back({4'h4, 8'h3C});
    xfer({8'h2B, 8'h04, 8'h3C}, 24, 0, 0, 1'b0, 1'b0);

    // R5: matching reads
    cur_req = "R5";
    exp_rd.push_back(4'h6);
    xfer({8'h38, 8'h06, 8'h00}, 24, 0, 0, 1'b1, 1'b0);
    exp_rd.push_back(4'hD);
    xfer({8'h39, 8'hFD, 8'hFF}, 24, 0, 0, 1'b1, 1'b0);

    // R6: device field mismatch
    cur_req = "R6";
    xfer({8'h24, 8'h0B, 8'h55}, 24, 0, 0, 1'b0, 1'b0);
    xfer({8'h34, 8'h06, 8'h00}, 24, 0, 0, 1'b0, 1'b0);

    // R7: unknown operation code
    cur_req = "R7";
    xfer({8'h58, 8'h02, 8'h99}, 24, 0, 0, 1'b0, 1'b0);

    // R9: pause in the middle of a write and of a read
    cur_req = "R9";
    exp_wr.push_back({4'h9, 8'hC3});
    xfer({8'h28, 8'h09, 8'hC3}, 24, 1, 11, 1'b0, 1'b0);
    exp_rd.push_back(4'h2);
    xfer({8'h38, 8'h02, 8'h00}, 24, 1, 19, 1'b1, 1'b0);

    // R8: pause requested while the clock is high, during read data
    cur_req = "R8";
    exp_rd.push_back(4'hE);
    xfer({8'h3A, 8'h0E, 8'h00}, 24, 2, 20, 1'b1, 1'b0);

    // R10: deselect mid data byte, then a clean frame
    cur_req = "R10";
    xfer({8'h28, 8'h01, 8'hF0}, 20, 0, 0, 1'b0, 1'b0);
    exp_wr.push_back({4'h7, 8'h81});
    xfer({8'h28, 8'h07, 8'h81}, 24, 0, 0, 1'b0, 1'b0);

    // R12: deselect together with the final rising edge
    cur_req = "R12";
    xfer({8'h28, 8'h03, 8'h66}, 24, 0, 0, 1'b0, 1'b1);

    wait_n(20);
    check(exp_wr.size() == 0, "R4 all writes seen", 16'(exp_wr.size()), 16'h0);
    check(exp_rd.size() == 0, "R5 all reads seen", 16'(exp_rd.size()), 16'h0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule